// File: doc/BRIEF.md
# Sized Integer Adder-Subtractor with Condition Flags

This block is the arithmetic slice of an integer datapath. Each cycle it can take a destination operand and a source operand, both 32 bits wide, and apply one of five operations: add, subtract, add-with-extend, quick add of a small constant, or address add. A size code picks how many low bits take part: 8, 16 or 32. The result is merged into the destination, so bits above the active size keep the destination's value. The new value and a five-bit condition register are held in output registers. The flags are computed over the active size only.

The extend flag copies the carry. Add-with-extend reads the extend flag as its carry-in, so several of these operations in a row build a wider add. The address-add path works on the full 32 bits. It sign-extends a 16-bit source, and it never touches the flags. The surrounding pipeline drives the operands and asserts the write strobe in each cycle where a result should be committed.

Top module: `sized_arith_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` becomes 0 and `ccr_o` becomes 0.
- R2: At an edge where `wr_en` is low, `result_o` and `ccr_o` hold their values, whatever the other inputs are.
- R3: For an arithmetic operation (add 0, subtract 1, add-with-extend 2, quick add 4), the size code `size_i` (0 = 8 bits, 1 = 16 bits, 2 = 32 bits) decides how many low bits of `result_o` take the sized result. The remaining upper bits are copied from `dst_i`.
- R4: After an arithmetic write, N (`ccr_o[3]`) equals the top bit of the sized result. Z (`ccr_o[2]`) is 1 exactly when all bits of the sized result are zero.
- R5: For add (op 0), the sized result is dst + src. C (`ccr_o[0]`) is the carry out of the sized top bit. V (`ccr_o[1]`) is set when two operands of equal sign give a result of the other sign. X (`ccr_o[4]`) equals C.
- R6: For subtract (op 1), the sized result is dst − src. C is set on a borrow, meaning unsigned dst < src within the size. V is set when the operand signs differ and the result sign differs from the destination sign. X equals C.
- R7: Add-with-extend (op 2) computes dst + src + X, where X is the registered extend flag from before the edge. Its flags follow the rules of R5.
- R8: Quick add (op 4) adds a constant taken from `imm_i`. Codes 1 to 7 stand for the values 1 to 7, and code 0 stands for 8. Flags and merging follow R3 to R5.
- R9: Address add (op 3) with size 1 writes dst + the sign-extended low 16 bits of src. With size 2 it writes dst + src over all 32 bits. With size 0 nothing changes. In every case `ccr_o` is unchanged.
- R10: An opcode of 5, 6 or 7, or a size code of 3, leaves both `result_o` and `ccr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: commit result and flags at this edge |
| op_i | input | 3 | Operation code: 0 add, 1 subtract, 2 add-with-extend, 3 address add, 4 quick add |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| imm_i | input | 3 | Quick-add constant code (0 means 8) |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| result_o | output | 32 | Registered merged destination value |
| ccr_o | output | 5 | Registered flags, bit 4 to bit 0: X, N, Z, V, C |

## Verification
Add-with-extend is the case where two functions meet at the same edge. At that edge the flag register is read, because X feeds the carry-in, and it is also rewritten with the new X. The bench provokes this by running long chains of back-to-back add-with-extend writes with no idle cycles between them. The byte operands are swept so that X alternates between 0 and 1. Every write is judged against a bench model that takes X from the flags it expected in the previous cycle.

A second overlap is an address-add write placed directly after an arithmetic write. Here the result changes while the flags must keep the values the earlier operation produced.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDX = 3'd2,
    OP_ADDA = 3'd3,
    OP_ADDQ = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/sau_operand_prep.sv
module sau_operand_prep
  import sau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 3
) (
  input  logic [2:0]        op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              x_i,
  output logic [DATA_W-1:0] b_o,
  output logic              cin_o,
  output logic              is_sub_o
);
  localparam int PAD_W = DATA_W - IMM_W - 1;

  logic [DATA_W-1:0] quick_val;
  // code zero stands for the largest value, 2**IMM_W
  assign quick_val = {{PAD_W{1'b0}}, (imm_i == '0), imm_i};

  always_comb begin
    b_o      = src_i;
    cin_o    = 1'b0;
    is_sub_o = 1'b0;
    case (op_i)
      OP_SUB: begin
        b_o      = ~src_i;
        cin_o    = 1'b1;
        is_sub_o = 1'b1;
      end
      OP_ADDX: cin_o = x_i;
      OP_ADDQ: b_o   = quick_val;
      default: ;
    endcase
  end
endmodule

// File: rtl/sau_lane.sv
module sau_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         is_sub_i,
  output logic [W-1:0] sum_o,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);
  logic [W:0] full;

  assign full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o = full[W-1:0];
  assign n_o   = full[W-1];
  assign z_o   = (full[W-1:0] == '0);
  // b_i is already inverted for subtract, so one sign rule covers both
  assign v_o   = (a_i[W-1] == b_i[W-1]) && (full[W-1] != a_i[W-1]);
  // the carry of a + ~b + 1 is the complement of the borrow
  assign c_o   = full[W] ^ is_sub_i;
endmodule

// File: rtl/sau_addr_add.sv
module sau_addr_add #(
  parameter int DATA_W = 32
) (
  input  logic              long_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] src_ext;

  assign src_ext = long_i ? src_i : {{HALF_W{src_i[HALF_W-1]}}, src_i[HALF_W-1:0]};
  assign sum_o   = dst_i + src_ext;
endmodule

// File: rtl/sized_arith_unit.sv
module sized_arith_unit
  import sau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] result_o,
  output logic [4:0]        ccr_o
);
  localparam int N_LANES = 3;

  ccr_t              ccr_q;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] b_op;
  logic              cin;
  logic              is_sub;
  logic [DATA_W-1:0] addr_sum;

  logic [N_LANES:0][DATA_W-1:0] lane_res;
  ccr_t [N_LANES:0]             lane_ccr;

  logic arith_op;
  logic arith_ok;
  logic addr_ok;

  sau_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
    .op_i     (op_i),
    .imm_i    (imm_i),
    .src_i    (src_i),
    .x_i      (ccr_q.x),
    .b_o      (b_op),
    .cin_o    (cin),
    .is_sub_o (is_sub)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (N_LANES - 1 - g);
    logic [LW-1:0] s;
    logic ln, lz, lv, lc;

    sau_lane #(.W(LW)) u_lane (
      .a_i      (dst_i[LW-1:0]),
      .b_i      (b_op[LW-1:0]),
      .cin_i    (cin),
      .is_sub_i (is_sub),
      .sum_o    (s),
      .n_o      (ln),
      .z_o      (lz),
      .v_o      (lv),
      .c_o      (lc)
    );

    if (LW < DATA_W) begin : g_part
      assign lane_res[g] = {dst_i[DATA_W-1:LW], s};
    end else begin : g_whole
      assign lane_res[g] = s;
    end
    assign lane_ccr[g] = {lc, ln, lz, lv, lc};
  end

  assign lane_res[N_LANES] = '0;
  assign lane_ccr[N_LANES] = '0;

  sau_addr_add #(.DATA_W(DATA_W)) u_addr (
    .long_i (size_i == SZ_LONG),
    .src_i  (src_i),
    .dst_i  (dst_i),
    .sum_o  (addr_sum)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_ADDX, OP_ADDQ: arith_op = 1'b1;
      default:                          arith_op = 1'b0;
    endcase
  end

  assign arith_ok = arith_op && (size_i != 2'd3);
  assign addr_ok  = (op_i == OP_ADDA) && (size_i == SZ_WORD || size_i == SZ_LONG);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ccr_q <= '0;
    end else if (wr_en) begin
      if (arith_ok) begin
        res_q <= lane_res[size_i];
        ccr_q <= lane_ccr[size_i];
      end else if (addr_ok) begin
        res_q <= addr_sum;
      end
    end
  end

  assign result_o = res_q;
  assign ccr_o    = ccr_q;
endmodule

// File: rtl/sau_checker.sv
module sau_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        op_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] result_o,
  input logic [4:0]        ccr_o
);
  localparam int BW = DATA_W / 4;

  logic arith_wr;
  assign arith_wr = wr_en && (op_i == 3'd0 || op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd4)
                    && (size_i != 2'd3);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(result_o) && $stable(ccr_o)));

  p_upper_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (arith_wr && size_i == 2'd0) |=> (result_o[DATA_W-1:BW] == $past(dst_i[DATA_W-1:BW])));

  p_nz_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (arith_wr && size_i == 2'd0) |=> (ccr_o[3] == result_o[BW-1] && ccr_o[2] == (result_o[BW-1:0] == '0)));

  // R5 and R6 both require that X copies C
  p_x_follows_c_r5: assert property (@(posedge clk) disable iff (rst)
    arith_wr |=> (ccr_o[4] == ccr_o[0]));

  p_addr_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_i == 3'd3) |=> $stable(ccr_o));

  p_undef_code_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (op_i > 3'd4 || size_i == 2'd3)) |=> ($stable(result_o) && $stable(ccr_o)));
endmodule

bind sized_arith_unit sau_checker #(.DATA_W(DATA_W)) u_sau_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .op_i     (op_i),
  .size_i   (size_i),
  .dst_i    (dst_i),
  .result_o (result_o),
  .ccr_o    (ccr_o)
);

// File: tb/sized_arith_unit_test.sv
`timescale 1ns/1ps
module sized_arith_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  op_i;
  logic [1:0]  size_i;
  logic [2:0]  imm_i;
  logic [31:0] src_i;
  logic [31:0] dst_i;
  logic [31:0] result_o;
  logic [4:0]  ccr_o;

  int checks   = 0;
  int failures = 0;

  logic [31:0] exp_res;
  logic [4:0]  exp_ccr;

  always #10 clk = ~clk;

  sized_arith_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .op_i(op_i), .size_i(size_i),
    .imm_i(imm_i), .src_i(src_i), .dst_i(dst_i), .result_o(result_o), .ccr_o(ccr_o)
  );

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [36:0] ref_model(
      input logic [2:0] op, input logic [1:0] sz, input logic [2:0] imm,
      input logic [31:0] src, input logic [31:0] dst,
      input logic [31:0] prev_res, input logic [4:0] prev_ccr);
    int w;
    longint unsigned m, av, bv, r, tot, cin;
    longint lim, sa, sb, ss;
    logic c, v, n, z;
    logic [31:0] res;
    if (sz == 2'd3 || op > 3'd4 || (op == 3'd3 && sz == 2'd0))
      return {prev_ccr, prev_res};
    if (op == 3'd3) begin
      if (sz == 2'd1) res = dst + {{16{src[15]}}, src[15:0]};
      else            res = dst + src;
      return {prev_ccr, res};
    end
    w   = 8 << sz;
    m   = (64'd1 << w) - 1;
    lim = longint'(64'd1 << (w - 1));
    av  = {32'd0, dst} & m;
    bv  = (op == 3'd4) ? ((imm == 3'd0) ? 64'd8 : {61'd0, imm}) : ({32'd0, src} & m);
    cin = (op == 3'd2) ? {63'd0, prev_ccr[4]} : 64'd0;
    sa  = longint'(av); if (sa >= lim) sa = sa - 2 * lim;
    sb  = longint'(bv); if (sb >= lim) sb = sb - 2 * lim;
    if (op == 3'd1) begin
      r  = (av - bv) & m;
      c  = (av < bv);
      ss = sa - sb;
    end else begin
      tot = av + bv + cin;
      r   = tot & m;
      c   = ((tot >> w) != 0);
      ss  = sa + sb + longint'(cin);
    end
    v   = (ss >= lim) || (ss < -lim);
    n   = ((r >> (w - 1)) & 64'd1) != 0;
    z   = (r == 0);
    res = (dst & ~m[31:0]) | r[31:0];
    return {c, n, z, v, c, res};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op, input logic [1:0] sz);
    if (sz == 2'd3 || op > 3'd4) return "R10";
    case (op)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R9";
      default: return "R8";
    endcase
  endfunction

  // call at a falling edge; commits one write and checks at the next falling edge
  task automatic apply(input logic [2:0] op, input logic [1:0] sz, input logic [2:0] imm,
                       input logic [31:0] src, input logic [31:0] dst);
    logic [36:0] e;
    bit arith;
    e = ref_model(op, sz, imm, src, dst, exp_res, exp_ccr);
    arith = (op != 3'd3) && (op <= 3'd4) && (sz != 2'd3);
    wr_en = 1'b1; op_i = op; size_i = sz; imm_i = imm; src_i = src; dst_i = dst;
    @(negedge clk);
    exp_res = e[31:0];
    exp_ccr = e[36:32];
    check(arith ? "R3" : op_tag(op, sz), result_o, exp_res);
    if (arith) check("R4", {30'd0, ccr_o[3:2]}, {30'd0, exp_ccr[3:2]});
    check(op_tag(op, sz), {27'd0, ccr_o}, {27'd0, exp_ccr});
  endtask

  task automatic idle_check(input logic [31:0] src, input logic [31:0] dst);
    wr_en = 1'b0; op_i = 3'd1; size_i = 2'd2; src_i = src; dst_i = dst;
    @(negedge clk);
    check("R2", result_o, exp_res);
    check("R2", {27'd0, ccr_o}, {27'd0, exp_ccr});
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; op_i = 3'd0; size_i = 2'd0; imm_i = 3'd0;
    src_i = 32'd0; dst_i = 32'd0;
    exp_res = 32'd0; exp_ccr = 5'd0;
    @(negedge clk);
    // R1: write strobe during reset must not matter
    wr_en = 1'b1; src_i = 32'hFFFF_FFFF; dst_i = 32'h1234_5678;
    @(negedge clk);
    check("R1", result_o, 32'd0);
    check("R1", {27'd0, ccr_o}, 32'd0);
    rst = 1'b0; wr_en = 1'b0;
    @(negedge clk);

    // byte sweep: add, subtract, and chained add-with-extend (R3 R4 R5 R6 R7)
    for (int a = 0; a < 256; a += 3) begin
      for (int b = 0; b < 256; b += 11) begin
        apply(3'd0, 2'd0, 3'd0, {24'hA5C3E1, b[7:0]}, {24'h5A3C1E, a[7:0]});
        apply(3'd1, 2'd0, 3'd0, {24'h0F0F0F, b[7:0]}, {24'hF0F0F0, a[7:0]});
        apply(3'd2, 2'd0, 3'd0, {24'h123456, b[7:0]}, {24'h89ABCD, a[7:0]});
        apply(3'd2, 2'd0, 3'd0, {24'h0, a[7:0]}, {24'hFFFFFF, b[7:0]});
      end
    end

    // word sweep
    for (int a = 0; a < 65536; a += 4099) begin
      for (int b = 0; b < 65536; b += 3001) begin
        apply(3'd0, 2'd1, 3'd0, {16'hBEEF, b[15:0]}, {16'hCAFE, a[15:0]});
        apply(3'd1, 2'd1, 3'd0, {16'h1111, b[15:0]}, {16'h7777, a[15:0]});
        apply(3'd2, 2'd1, 3'd0, {16'h2222, b[15:0]}, {16'h3333, a[15:0]});
      end
    end

    // long corner values
    begin
      logic [31:0] corners [8];
      corners = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                  32'hFFFF_FFFF, 32'h1234_5678, 32'hABCD_EF12, 32'h8000_0001};
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          apply(3'd0, 2'd2, 3'd0, corners[j], corners[i]);
          apply(3'd1, 2'd2, 3'd0, corners[j], corners[i]);
          apply(3'd2, 2'd2, 3'd0, corners[j], corners[i]);
        end
      end
    end

    // R8: every quick code at each size, including code 0 meaning 8
    for (int k = 0; k < 8; k++) begin
      apply(3'd4, 2'd0, k[2:0], 32'hDEAD_BEEF, 32'h1234_56FC);
      apply(3'd4, 2'd1, k[2:0], 32'h0,         32'h0000_7FFB);
      apply(3'd4, 2'd2, k[2:0], 32'h0,         32'hFFFF_FFF9);
    end

    // R9: address add after an arithmetic write that left flags set
    apply(3'd0, 2'd0, 3'd0, 32'h0000_00FF, 32'h0000_0001);   // Z and C set
    apply(3'd3, 2'd1, 3'd0, 32'h0000_AAAA, 32'h0000_1111);   // sign-extended
    apply(3'd3, 2'd2, 3'd0, 32'h0000_AAAA, 32'h0000_1111);   // full width
    apply(3'd3, 2'd1, 3'd0, 32'h1234_7FFF, 32'hFFFF_0001);
    apply(3'd3, 2'd0, 3'd0, 32'h0000_0055, 32'h0000_0022);   // byte size: no change

    // R10: undefined opcodes and size code 3
    for (int k = 5; k < 8; k++) apply(k[2:0], 2'd2, 3'd1, 32'h1, 32'h7FFF_FFFF);
    apply(3'd0, 2'd3, 3'd0, 32'hFF, 32'hFF);
    apply(3'd1, 2'd3, 3'd0, 32'h1,  32'h0);

    // R2: strobe low with changing inputs
    apply(3'd1, 2'd0, 3'd0, 32'h1, 32'h0);                   // N, C, X set
    idle_check(32'h5555_5555, 32'hAAAA_AAAA);
    idle_check(32'h0, 32'h0);

    // R1 again after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_res = 32'd0; exp_ccr = 5'd0;
    check("R1", result_o, 32'd0);
    check("R1", {27'd0, ccr_o}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule